// File: doc/BRIEF.md
# Application-Aware Injection Throttle Controller

This block sits beside a bufferless on-chip network. It watches every node and decides which nodes must hold back their memory request traffic. Each node reports three things. A pulse marks each retired instruction. A request shows that the core wants to inject a packet. A grant shows that the router accepted the packet this cycle. A node is starved in a cycle when its request reaches the router but is not granted.

The block works over a fixed window of `INTERVAL` cycles, 100,000 by default. In each window it counts, for every node, the starved cycles, the retired instructions and the accepted packets. On the last cycle of the window it checks the starvation counts against a programmable fraction of the window. If any node goes over that fraction, the network counts as congested. In that case each node gets a throttle rate from a small table. The table is indexed by the node's instructions-per-packet band, so nodes that need many packets per instruction are held back hardest.

A per-node gate enforces the rate. Out of every 16 cycles it blocks the node's request for the first N cycles, where N is the assigned rate. The rates and the congestion flag stay in force for one whole window. The counters are cleared at each window boundary.

Top module: `inject_throttle_top`

## Requirements
- R1: While reset is asserted, and just after it, every throttle rate is 0 and `congested` is 0. With every rate at 0, `gatedReq` equals `injReq`.
- R2: Rates and `congested` change only on a window boundary, once every `INTERVAL` cycles, counted from reset release. Between boundaries they hold their previous values.
- R3: A node's cycle counts as starved when its `gatedReq` bit is 1 and its `injGrant` bit is 0. Congestion is declared when, for any node, starved × 256 > `starveThresh` × `INTERVAL` over the window. `starveThresh` is a fraction in units of 1/256.
- R4: When congested, each node gets a rate from its retired-instruction count I and its accepted-packet count P, where a packet is `gatedReq` and `injGrant` both 1. With cutoff C, the rate is 12 if 4·I < C·P. Otherwise it is 8 if 2·I < C·P. Otherwise it is 4 if I < C·P. Otherwise it is 0. A node with P = 0 therefore gets 0.
- R5: When the window is not congested, every node's rate is 0.
- R6: With rate N (4-bit field), a request held high is blocked in exactly N of any 16 consecutive cycles. A rate of 0 never blocks, and `gatedReq` is never 1 while `injReq` is 0.
- R7: All per-node counts restart from zero at each boundary. A quiet window after a congested one yields `congested` = 0 and all rates 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| starveThresh | input | THR_W | Starvation fraction limit, units of 1/256 |
| ippCutoff | input | CUT_W | Instructions-per-packet cutoff C |
| retirePulse | input | NODES | One pulse per retired instruction, per node |
| injReq | input | NODES | Core wants to inject a memory request |
| injGrant | input | NODES | Router accepts the gated request this cycle |
| gatedReq | output | NODES | Request passed on to the router after throttling |
| rateOut | output | NODES*RATE_W | Current throttle rate per node, node n at bits [n*RATE_W +: RATE_W] |
| congested | output | 1 | Last completed window was declared congested |

## Verification
A wrong per-node count or a wrong band decision stays hidden until the window closes. It then shows up on `rateOut` in the cycle after the boundary, as a value that differs from the band formula, and it stays wrong for the whole next window. A bad gate phase or a bad rate shows up at `gatedReq` within 16 cycles as the wrong number of blocked cycles. A counter that is not cleared shows up one window later as a false congestion flag after quiet traffic. The bench therefore checks the rates just after each boundary, counts blocked cycles over a full 16-cycle period, and follows every congested window with a quiet one.

// File: rtl/throttle_pkg.sv
package throttle_pkg;
  // Strobes from the window control to the datapath
  typedef struct packed {
    logic sample;  // last cycle of window: latch new decision
    logic clear;   // last cycle of window: restart per-node counts
  } ctrlStrobe_t;
endpackage

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
#(
  parameter int INTERVAL = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  output ctrlStrobe_t stb
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] winCnt;
  logic          lastCycle;

  assign lastCycle = (winCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          winCnt <= '0;
    else if (lastCycle) winCnt <= '0;
    else                winCnt <= winCnt + 1'b1;
  end

  always_comb begin
    stb.sample = lastCycle;
    stb.clear  = lastCycle;
  end
endmodule

// File: rtl/throttle_gate.sv
module throttle_gate #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rate,
  input  logic              req,
  output logic              gated
);
  logic [RATE_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  // first `rate` phases of each period are blocked
  assign gated = req & (phase >= rate);
endmodule

// File: rtl/throttle_datapath.sv
module throttle_datapath
  import throttle_pkg::*;
#(
  parameter int NODES       = 4,
  parameter int INTERVAL    = 100000,
  parameter int THR_W       = 8,
  parameter int CUT_W       = 8,
  parameter int RATE_W      = 4,
  parameter int RATE_SEVERE = 12,
  parameter int RATE_MID    = 8,
  parameter int RATE_MILD   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              stb,
  input  logic [THR_W-1:0]         starveThresh,
  input  logic [CUT_W-1:0]         ippCutoff,
  input  logic [NODES-1:0]         retirePulse,
  input  logic [NODES-1:0]         injReq,
  input  logic [NODES-1:0]         injGrant,
  output logic [NODES-1:0]         gatedReq,
  output logic [NODES*RATE_W-1:0]  rateOut,
  output logic                     congested
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam int STV_W = CNT_W + THR_W + 1;
  localparam int IPP_W = CNT_W + CUT_W + 2;
  localparam logic [RATE_W-1:0] RATE_TBL [4] = '{
    RATE_W'(RATE_SEVERE), RATE_W'(RATE_MID), RATE_W'(RATE_MILD), RATE_W'(0)
  };

  logic [NODES-1:0]  overNode;
  logic [RATE_W-1:0] bandRate [NODES];
  logic [RATE_W-1:0] rateReg  [NODES];
  logic              anyOver;
  logic              congReg;

  assign anyOver   = |overNode;
  assign congested = congReg;

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [CNT_W-1:0] starveCnt, retireCnt, pktCnt;
    logic [CNT_W-1:0] starveNext, retireNext, pktNext;
    logic [STV_W-1:0] starveScaled, starveLimit;
    logic [IPP_W-1:0] instr4, instr2, instr1, pktScaled;
    logic [1:0]       band;

    always_comb begin
      starveNext   = starveCnt + CNT_W'(gatedReq[n] & ~injGrant[n]);
      pktNext      = pktCnt    + CNT_W'(gatedReq[n] &  injGrant[n]);
      retireNext   = retireCnt + CNT_W'(retirePulse[n]);
      starveScaled = STV_W'(starveNext) << THR_W;
      starveLimit  = STV_W'(starveThresh) * STV_W'(INTERVAL);
      overNode[n]  = starveScaled > starveLimit;
      instr1       = IPP_W'(retireNext);
      instr2       = instr1 << 1;
      instr4       = instr1 << 2;
      pktScaled    = IPP_W'(ippCutoff) * IPP_W'(pktNext);
      if (instr4 < pktScaled)      band = 2'd0;
      else if (instr2 < pktScaled) band = 2'd1;
      else if (instr1 < pktScaled) band = 2'd2;
      else                         band = 2'd3;
      bandRate[n] = RATE_TBL[band];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        starveCnt <= '0;
        retireCnt <= '0;
        pktCnt    <= '0;
      end else if (stb.clear) begin
        starveCnt <= '0;
        retireCnt <= '0;
        pktCnt    <= '0;
      end else begin
        starveCnt <= starveNext;
        retireCnt <= retireNext;
        pktCnt    <= pktNext;
      end
    end

    throttle_gate #(.RATE_W(RATE_W)) u_gate (
      .clk   (clk),
      .rstN  (rstN),
      .rate  (rateReg[n]),
      .req   (injReq[n]),
      .gated (gatedReq[n])
    );

    assign rateOut[n*RATE_W +: RATE_W] = rateReg[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      congReg <= 1'b0;
      for (int n = 0; n < NODES; n++) rateReg[n] <= '0;
    end else if (stb.sample) begin
      congReg <= anyOver;
      for (int n = 0; n < NODES; n++) rateReg[n] <= anyOver ? bandRate[n] : '0;
    end
  end
endmodule

// File: rtl/inject_throttle_top.sv
module inject_throttle_top
  import throttle_pkg::*;
#(
  parameter int NODES       = 4,
  parameter int INTERVAL    = 100000,
  parameter int THR_W       = 8,
  parameter int CUT_W       = 8,
  parameter int RATE_W      = 4,
  parameter int RATE_SEVERE = 12,
  parameter int RATE_MID    = 8,
  parameter int RATE_MILD   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [THR_W-1:0]        starveThresh,
  input  logic [CUT_W-1:0]        ippCutoff,
  input  logic [NODES-1:0]        retirePulse,
  input  logic [NODES-1:0]        injReq,
  input  logic [NODES-1:0]        injGrant,
  output logic [NODES-1:0]        gatedReq,
  output logic [NODES*RATE_W-1:0] rateOut,
  output logic                    congested
);
  ctrlStrobe_t stb;

  throttle_ctrl #(.INTERVAL(INTERVAL)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb)
  );

  throttle_datapath #(
    .NODES(NODES), .INTERVAL(INTERVAL), .THR_W(THR_W), .CUT_W(CUT_W),
    .RATE_W(RATE_W), .RATE_SEVERE(RATE_SEVERE), .RATE_MID(RATE_MID),
    .RATE_MILD(RATE_MILD)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .starveThresh (starveThresh),
    .ippCutoff    (ippCutoff),
    .retirePulse  (retirePulse),
    .injReq       (injReq),
    .injGrant     (injGrant),
    .gatedReq     (gatedReq),
    .rateOut      (rateOut),
    .congested    (congested)
  );
endmodule

// File: rtl/throttle_chk.sv
module throttle_chk #(
  parameter int NODES    = 4,
  parameter int INTERVAL = 100000,
  parameter int RATE_W   = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NODES-1:0]        injReq,
  input logic [NODES-1:0]        gatedReq,
  input logic [NODES*RATE_W-1:0] rateOut,
  input logic                    congested
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0]    winPos;
  logic [NODES-1:0] passMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               winPos <= '0;
    else if (winPos == LAST) winPos <= '0;
    else                     winPos <= winPos + 1'b1;
  end

  always_comb begin
    for (int n = 0; n < NODES; n++) passMask[n] = (rateOut[n*RATE_W +: RATE_W] == '0);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (rateOut == '0 && !congested));

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winPos != LAST) |=> ($stable(rateOut) && $stable(congested)));

  // R5
  quiet_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !congested |-> (rateOut == '0));

  // R6
  no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gatedReq & ~injReq) == '0);

  // R6
  zero_rate_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((gatedReq ^ injReq) & passMask) == '0);
endmodule

bind inject_throttle_top throttle_chk #(
  .NODES(NODES), .INTERVAL(INTERVAL), .RATE_W(RATE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .injReq    (injReq),
  .gatedReq  (gatedReq),
  .rateOut   (rateOut),
  .congested (congested)
);

// File: tb/test_inject_throttle_top.sv
`timescale 1ns/1ps
module test_inject_throttle_top;
  localparam int NODES = 4;
  localparam int WIN   = 64;
  localparam int NV    = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [7:0]       starveThresh = 8'd64;   // 25 %: congested when starved > 16
  logic [7:0]       ippCutoff    = 8'd8;
  logic [NODES-1:0] retirePulse = '0;
  logic [NODES-1:0] injReq = '0;
  logic [NODES-1:0] injGrant = '0;
  logic [NODES-1:0] gatedReq;
  logic [NODES*4-1:0] rateOut;
  logic             congested;

  int chkCnt  = 0;
  int failCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  inject_throttle_top #(.NODES(NODES), .INTERVAL(WIN)) i_inject_throttle_top (
    .clk(clk), .rstN(rstN), .starveThresh(starveThresh), .ippCutoff(ippCutoff),
    .retirePulse(retirePulse), .injReq(injReq), .injGrant(injGrant),
    .gatedReq(gatedReq), .rateOut(rateOut), .congested(congested)
  );

  // per vector, per node: starved cycles, retired instructions, packets
  localparam int V_S [NV][NODES] = '{'{16,0,0,0}, '{17,0,0,0}, '{0,0,0,40}, '{20,20,20,20}};
  localparam int V_R [NV][NODES] = '{'{10,10,10,10}, '{10,30,50,60}, '{16,32,64,0}, '{63,63,63,63}};
  localparam int V_I [NV][NODES] = '{'{10,10,10,10}, '{10,10,10,0}, '{8,8,8,5}, '{1,1,1,1}};
  localparam int V_C [NV] = '{0, 1, 1, 1};
  localparam int V_E [NV][NODES] = '{'{0,0,0,0}, '{12,8,4,0}, '{8,4,0,12}, '{0,0,0,0}};

  task automatic chk(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rateOf(input int n);
    return int'(rateOut[n*4 +: 4]);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; retirePulse = '0; injReq = '0; injGrant = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 rates in reset", int'(rateOut), 0);
    chk("R1 congested in reset", int'(congested), 0);
  endtask

  // drive cycle c of a window at a falling edge
  task automatic driveCycle(input int v, input int c);
    for (int n = 0; n < NODES; n++) begin
      retirePulse[n] = (c < V_R[v][n]);
      injReq[n]      = (c < V_I[v][n] + V_S[v][n]);
      injGrant[n]    = (c < V_I[v][n]);
    end
  endtask

  initial begin
    for (int v = 0; v < NV; v++) begin
      doReset();
      rstN = 1'b1;
      driveCycle(v, 0);
      for (int c = 1; c < WIN; c++) begin
        @(negedge clk);
        driveCycle(v, c);
      end
      @(negedge clk);
      retirePulse = '0; injReq = '0; injGrant = '0;
      // R3 congestion decision, R5 zero rates when quiet
      chk($sformatf("R3 congested vec%0d", v), int'(congested), V_C[v]);
      for (int n = 0; n < NODES; n++)
        chk($sformatf("R4 R5 rate vec%0d node%0d", v, n), rateOf(n), V_E[v][n]);
      // R6 gate: count blocked cycles over one 16-cycle period
      begin
        int blocked [NODES];
        for (int n = 0; n < NODES; n++) blocked[n] = 0;
        injReq = '1; injGrant = '1;
        for (int k = 0; k < 16; k++) begin
          #1;
          for (int n = 0; n < NODES; n++) if (!gatedReq[n]) blocked[n]++;
          @(negedge clk);
        end
        for (int n = 0; n < NODES; n++)
          chk($sformatf("R6 blocked vec%0d node%0d", v, n), blocked[n], V_E[v][n]);
      end
      injReq = '0; injGrant = '0;
      for (int k = 16; k < WIN - 1; k++) @(negedge clk);
      // R2 rates hold until the boundary
      for (int n = 0; n < NODES; n++)
        chk($sformatf("R2 hold vec%0d node%0d", v, n), rateOf(n), V_E[v][n]);
      @(negedge clk);
      // R7 quiet window after boundary clears decision
      chk($sformatf("R7 congested cleared vec%0d", v), int'(congested), 0);
      chk($sformatf("R7 rates cleared vec%0d", v), int'(rateOut), 0);
    end
    // R1 / R6: zero rate passes requests unchanged
    doReset();
    rstN = 1'b1;
    injReq = 4'b1010;
    #1;
    chk("R1 pass-through after reset", int'(gatedReq), 4'b1010);
    injReq = 4'b0101;
    @(negedge clk);
    chk("R6 no block at rate zero", int'(gatedReq), 4'b0101);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  end
endmodule